// File: doc/BRIEF.md
# Shared-Pin GPIO Port

This block is an 8-bit general-purpose I/O port whose pins can be taken over by on-chip peripherals: an SPI controller (its data-out pin and its slave-select pin), a UART receiver (its receive pin) and two timer channels. Software reaches two registers over a simple single-cycle register bus. One is the output latch and the other is the direction register. Each pin is driven from these registers unless a peripheral currently owns it. While a peripheral owns a pin, that peripheral's output value and output-enable drive the pad.

Pad levels pass through a synchronizer. The synchronized levels feed both the port read path and the peripheral inputs. A port read still selects per bit between the latch and the live pin according to the direction register, whichever side owns the pin at the time. Pin positions are parameters. The defaults are UART receive on bit 1, timer channel 0 on bit 2, timer channel 1 on bit 3, SPI slave-select on bit 4 and SPI data-out on bit 5.

Top module: `gpio_share_port`

## Requirements
- R1: After reset the output latch and the direction register are 0, so with every peripheral disabled all padOe bits are 0 and a read of address 1 returns 0.
- R2: On a pin that no peripheral owns, padOe equals its direction bit and padOut equals its latch bit. A write with busWe=1 takes effect from the next clock edge: address 0 writes the latch and address 1 writes the direction register.
- R3: A read of address 0 returns, for each bit, the latch when the direction bit is 1 and the synchronized pin when it is 0. A pad change appears on busRdata and on syncPinOut after exactly two rising clock edges, and not after one.
- R4: While spiEn=1, the SPI data-out pin (bit 5) drives padOe=spiMisoOe and padOut=spiMisoOut, whatever its direction and latch bits hold.
- R5: The slave-select pin (bit 4) is owned by the SPI when spiEn=1, except when spiMaster=1 and spiModfEn=0. While owned it is an input (padOe=0, padOut=0). Otherwise it is plain GPIO.
- R6: Timer channel k (pin bit 2 for k=0, bit 3 for k=1) owns its pin when its 2-bit edge/level field is nonzero. It then drives padOe=tmrOe[k] and padOut=tmrOut[k]. With the field at 00 the pin is plain GPIO.
- R7: While uartEn=1, the receive pin (bit 1) is an input (padOe=0, padOut=0).
- R8: The read rule of R3 applies unchanged to bits that a peripheral owns.
- R9: Latch writes made while a peripheral owns a pin are kept, and they drive the pad once ownership ends.
- R10: A read of address 1 returns the direction register. Bits 0, 6 and 7 follow the latch and direction rules alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 1 | 0 = port data, 1 = direction |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data (combinational) |
| spiEn | input | 1 | SPI enabled |
| spiMaster | input | 1 | SPI in master mode |
| spiModfEn | input | 1 | SPI mode-fault detection enabled |
| spiMisoOut | input | 1 | SPI data-out pin value |
| spiMisoOe | input | 1 | SPI data-out pin enable |
| uartEn | input | 1 | UART enabled |
| tmrEls0 | input | 2 | Timer channel 0 edge/level field |
| tmrEls1 | input | 2 | Timer channel 1 edge/level field |
| tmrOut | input | 2 | Timer channel output values |
| tmrOe | input | 2 | Timer channel output enables |
| padIn | input | 8 | Pad input levels |
| padOut | output | 8 | Pad output values |
| padOe | output | 8 | Pad output enables |
| syncPinOut | output | 8 | Synchronized pin levels to peripherals |

## Verification
The bench sweeps all 256 direction values against a fixed pad pattern. It then sweeps all 256 combinations of the peripheral enable and mode inputs, and each combination gets its own direction and latch pattern. A design that let the direction bit win over an owning peripheral, or released slave-select on the wrong master/mode-fault combination, would show a wrong padOe bit. A design that changed read selection for owned pins would return the wrong read bits. The bench also checks the pin-to-read latency edge by edge, and checks that a latch write made during ownership is kept. A design with one synchronizer stage too few or too many, or one that dropped such a write, would be caught.

// File: rtl/gpio_share_pkg.sv
package gpio_share_pkg;
  typedef struct packed {
    logic wrLatch;
    logic wrDir;
  } portStrobe_t;

  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_DIR  = 1'b1;
endpackage

// File: rtl/port_own_ctrl.sv
module port_own_ctrl
  import gpio_share_pkg::*;
#(
  parameter int PORT_W   = 8,
  parameter int RXD_BIT  = 1,
  parameter int TCH0_BIT = 2,
  parameter int TCH1_BIT = 3,
  parameter int SS_BIT   = 4,
  parameter int MISO_BIT = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busAddr,
  input  logic              spiEn,
  input  logic              spiMaster,
  input  logic              spiModfEn,
  input  logic              spiMisoOut,
  input  logic              spiMisoOe,
  input  logic              uartEn,
  input  logic [1:0]        tmrEls0,
  input  logic [1:0]        tmrEls1,
  input  logic [1:0]        tmrOut,
  input  logic [1:0]        tmrOe,
  output portStrobe_t       strobe,
  output logic [PORT_W-1:0] ownMask,
  output logic [PORT_W-1:0] perOe,
  output logic [PORT_W-1:0] perOut
);
  logic misoOwned, ssOwned, tch0Owned, tch1Owned, rxdOwned;

  always_comb begin
    strobe.wrLatch = busWe && (busAddr == ADDR_DATA);
    strobe.wrDir   = busWe && (busAddr == ADDR_DIR);
  end

  always_comb begin
    misoOwned = spiEn;
    ssOwned   = spiEn && !(spiMaster && !spiModfEn);
    tch0Owned = |tmrEls0;
    tch1Owned = |tmrEls1;
    rxdOwned  = uartEn;
  end

  for (genvar i = 0; i < PORT_W; i++) begin : gPin
    if (i == MISO_BIT) begin : gMiso
      assign ownMask[i] = misoOwned;
      assign perOe[i]   = spiMisoOe;
      assign perOut[i]  = spiMisoOut;
    end else if (i == SS_BIT) begin : gSs
      assign ownMask[i] = ssOwned;
      assign perOe[i]   = 1'b0;
      assign perOut[i]  = 1'b0;
    end else if (i == TCH0_BIT) begin : gTch0
      assign ownMask[i] = tch0Owned;
      assign perOe[i]   = tmrOe[0];
      assign perOut[i]  = tmrOut[0];
    end else if (i == TCH1_BIT) begin : gTch1
      assign ownMask[i] = tch1Owned;
      assign perOe[i]   = tmrOe[1];
      assign perOut[i]  = tmrOut[1];
    end else if (i == RXD_BIT) begin : gRxd
      assign ownMask[i] = rxdOwned;
      assign perOe[i]   = 1'b0;
      assign perOut[i]  = 1'b0;
    end else begin : gPlain
      assign ownMask[i] = 1'b0;
      assign perOe[i]   = 1'b0;
      assign perOut[i]  = 1'b0;
    end
  end

  assert_ss_slave_input_R5: assert property (@(posedge clk) disable iff (!rstN)
    (spiEn && !spiMaster) |-> (ownMask[SS_BIT] && !perOe[SS_BIT]));

  assert_ss_released_R5: assert property (@(posedge clk) disable iff (!rstN)
    (spiMaster && !spiModfEn) |-> !ownMask[SS_BIT]);

  assert_rxd_input_R7: assert property (@(posedge clk) disable iff (!rstN)
    uartEn |-> (ownMask[RXD_BIT] && !perOe[RXD_BIT]));

  assert_tmr_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (tmrEls0 == 2'b00 && tmrEls1 == 2'b00) |-> !(ownMask[TCH0_BIT] || ownMask[TCH1_BIT]));

  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.wrLatch && strobe.wrDir));
endmodule

// File: rtl/port_pin_path.sv
module port_pin_path
  import gpio_share_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStrobe_t       strobe,
  input  logic              busAddr,
  input  logic [PORT_W-1:0] busWdata,
  input  logic [PORT_W-1:0] ownMask,
  input  logic [PORT_W-1:0] perOe,
  input  logic [PORT_W-1:0] perOut,
  input  logic [PORT_W-1:0] padIn,
  output logic [PORT_W-1:0] padOut,
  output logic [PORT_W-1:0] padOe,
  output logic [PORT_W-1:0] syncPinOut,
  output logic [PORT_W-1:0] busRdata
);
  logic [PORT_W-1:0] latchReg, dirReg;
  logic [PORT_W-1:0] syncPipe [SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchReg <= '0;
      dirReg   <= '0;
    end else begin
      if (strobe.wrLatch) latchReg <= busWdata;
      if (strobe.wrDir)   dirReg   <= busWdata;
    end
  end

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncPipe[s] <= '0;
      else if (s == 0) syncPipe[s] <= padIn;
      else syncPipe[s] <= syncPipe[(s == 0) ? 0 : s - 1];
    end
  end

  assign syncPinOut = syncPipe[SYNC_STAGES-1];

  always_comb begin
    padOe  = (ownMask & perOe)  | (~ownMask & dirReg);
    padOut = (ownMask & perOut) | (~ownMask & latchReg);
  end

  always_comb begin
    if (busAddr == ADDR_DIR) busRdata = dirReg;
    else busRdata = (dirReg & latchReg) | (~dirReg & syncPinOut);
  end

  logic [1:0] ageCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ageCnt <= '0;
    else if (ageCnt != 2'd3) ageCnt <= ageCnt + 2'd1;
  end

  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrDir |=> (dirReg == $past(busWdata)));

  assert_latch_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrLatch |=> $stable(latchReg));

  assert_dir_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrDir |=> $stable(dirReg));

  if (SYNC_STAGES == 2) begin : gSyncChk
    assert_sync_delay_R3: assert property (@(posedge clk) disable iff (!rstN)
      (ageCnt >= 2'd2) |-> (syncPinOut == $past(padIn, 2)));
  end
endmodule

// File: rtl/gpio_share_port.sv
module gpio_share_port
  import gpio_share_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RXD_BIT     = 1,
  parameter int TCH0_BIT    = 2,
  parameter int TCH1_BIT    = 3,
  parameter int SS_BIT      = 4,
  parameter int MISO_BIT    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busAddr,
  input  logic [PORT_W-1:0] busWdata,
  output logic [PORT_W-1:0] busRdata,
  input  logic              spiEn,
  input  logic              spiMaster,
  input  logic              spiModfEn,
  input  logic              spiMisoOut,
  input  logic              spiMisoOe,
  input  logic              uartEn,
  input  logic [1:0]        tmrEls0,
  input  logic [1:0]        tmrEls1,
  input  logic [1:0]        tmrOut,
  input  logic [1:0]        tmrOe,
  input  logic [PORT_W-1:0] padIn,
  output logic [PORT_W-1:0] padOut,
  output logic [PORT_W-1:0] padOe,
  output logic [PORT_W-1:0] syncPinOut
);
  portStrobe_t       strobe;
  logic [PORT_W-1:0] ownMask, perOe, perOut;

  port_own_ctrl #(
    .PORT_W(PORT_W), .RXD_BIT(RXD_BIT), .TCH0_BIT(TCH0_BIT),
    .TCH1_BIT(TCH1_BIT), .SS_BIT(SS_BIT), .MISO_BIT(MISO_BIT)
  ) ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .spiEn(spiEn), .spiMaster(spiMaster), .spiModfEn(spiModfEn),
    .spiMisoOut(spiMisoOut), .spiMisoOe(spiMisoOe), .uartEn(uartEn),
    .tmrEls0(tmrEls0), .tmrEls1(tmrEls1), .tmrOut(tmrOut), .tmrOe(tmrOe),
    .strobe(strobe), .ownMask(ownMask), .perOe(perOe), .perOut(perOut)
  );

  port_pin_path #(.PORT_W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busAddr(busAddr),
    .busWdata(busWdata), .ownMask(ownMask), .perOe(perOe), .perOut(perOut),
    .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .syncPinOut(syncPinOut), .busRdata(busRdata)
  );
endmodule

// File: tb/gpio_share_port_test.sv
`timescale 1ns/1ps
module gpio_share_port_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWe = 1'b0, busAddr = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic spiEn = 0, spiMaster = 0, spiModfEn = 0, spiMisoOut = 0, spiMisoOe = 0, uartEn = 0;
  logic [1:0] tmrEls0 = 0, tmrEls1 = 0, tmrOut = 0, tmrOe = 0;
  logic [7:0] padIn = 8'hA5;
  logic [7:0] padOut, padOe, syncPinOut;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  gpio_share_port uut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .spiEn(spiEn), .spiMaster(spiMaster), .spiModfEn(spiModfEn),
    .spiMisoOut(spiMisoOut), .spiMisoOe(spiMisoOe), .uartEn(uartEn),
    .tmrEls0(tmrEls0), .tmrEls1(tmrEls1), .tmrOut(tmrOut), .tmrOe(tmrOe),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .syncPinOut(syncPinOut)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic addr, input logic [7:0] data);
    @(negedge clk);
    busWe = 1'b1; busAddr = addr; busWdata = data;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic readReg(input logic addr, output logic [7:0] data);
    busAddr = addr;
    #1 data = busRdata;
  endtask

  // Independent model of pad drive from the requirements
  function automatic void model(input logic [7:0] dir, input logic [7:0] lat,
                                output logic [7:0] oe, output logic [7:0] out);
    oe = dir; out = lat;
    if (spiEn) begin oe[5] = spiMisoOe; out[5] = spiMisoOut; end              // R4
    if (spiEn && !(spiMaster && !spiModfEn)) begin oe[4] = 0; out[4] = 0; end  // R5
    if (tmrEls0 != 0) begin oe[2] = tmrOe[0]; out[2] = tmrOut[0]; end         // R6
    if (tmrEls1 != 0) begin oe[3] = tmrOe[1]; out[3] = tmrOut[1]; end         // R6
    if (uartEn) begin oe[1] = 0; out[1] = 0; end                              // R7
  endfunction

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    logic [7:0] rd, eo, ep;
    repeat (3) @(negedge clk);
    // R1: reset state
    readReg(1'b1, rd); check("R1 dir reset", rd, 8'h00);
    check("R1 oe reset", padOe, 8'h00);
    rstN = 1'b1;
    padIn = 8'hC3;
    repeat (3) @(negedge clk);

    // R2, R3, R10: sweep all direction values with peripherals off
    for (int v = 0; v < 256; v++) begin
      logic [7:0] lat;
      lat = 8'(v) ^ 8'h5A;
      writeReg(1'b1, 8'(v));
      writeReg(1'b0, lat);
      #1;
      check("R2 padOe", padOe, 8'(v));
      check("R2 padOut", padOut, lat);
      readReg(1'b1, rd); check("R10 dir read", rd, 8'(v));
      readReg(1'b0, rd); check("R3 data read", rd, (8'(v) & lat) | (~8'(v) & 8'hC3));
    end

    // R3: exact synchronizer latency
    writeReg(1'b1, 8'h00);
    @(negedge clk); padIn = 8'h00;
    repeat (3) @(negedge clk);
    padIn = 8'hFF;
    @(posedge clk); #1;
    readReg(1'b0, rd); check("R3 one edge", rd, 8'h00);
    check("R3 sync one edge", syncPinOut, 8'h00);
    @(posedge clk); #1;
    readReg(1'b0, rd); check("R3 two edges", rd, 8'hFF);
    check("R3 sync two edges", syncPinOut, 8'hFF);

    // R4, R5, R6, R7, R8: sweep every peripheral configuration
    padIn = 8'h96;
    for (int c = 0; c < 256; c++) begin
      logic [7:0] dir, lat;
      dir = 8'(c * 37 + 11);
      lat = 8'(c * 91 + 5);
      writeReg(1'b1, dir);
      writeReg(1'b0, lat);
      @(negedge clk);
      spiEn = c[0]; spiMaster = c[1]; spiModfEn = c[2]; uartEn = c[3];
      tmrEls0 = 2'(c >> 4); tmrEls1 = 2'(c >> 6);
      spiMisoOe = c[1]; spiMisoOut = ~c[4];
      tmrOe = {c[5], c[7]}; tmrOut = {~c[0], c[6]};
      #1;
      model(dir, lat, eo, ep);
      check("R4/R5/R6/R7 padOe", padOe, eo);
      check("R4/R5/R6/R7 padOut", padOut, ep);
      readReg(1'b0, rd); check("R8 owned read", rd, (dir & lat) | (~dir & 8'h96));
      @(negedge clk);
      spiEn = 0; uartEn = 0; tmrEls0 = 0; tmrEls1 = 0;
    end

    // R9: latch write during ownership is kept
    writeReg(1'b1, 8'h20);
    writeReg(1'b0, 8'h00);
    @(negedge clk); spiEn = 1; spiMisoOe = 1; spiMisoOut = 0;
    writeReg(1'b0, 8'h20);
    #1 check("R9 owned drive", padOut & 8'h20, 8'h00);
    @(negedge clk); spiEn = 0;
    #1 check("R9 released drive", padOut & 8'h20, 8'h20);
    check("R9 released oe", padOe & 8'h20, 8'h20);

    finish();
  end
endmodule